// File: doc/BRIEF.md
# Statistical Sample Operation Selector

This block watches a stream of eligible operations, one strobe per cycle, and picks one of them for profiling every N operations. A down-counter is reloaded with the programmed interval whenever it expires. The operation that arrives in the expiring cycle is marked with a one-cycle tag pulse. An optional jitter mode adds a pseudo-random offset to each reload, so that the sampling period does not lock onto the period of a program loop.

Only one tagged operation may be in flight at a time. A busy flag is set by the tag and cleared by the completion strobe of the tagged operation. If the counter expires while the flag is still set, the new sample is dropped and a collision event is raised.

Three event pulses feed external performance counters:
- population, for every eligible operation;
- feed, for every counter expiry;
- collision, for every dropped sample.

Record capture, filtering and buffering happen downstream, so collisions are reported before any filtering.

Top module: `op_sample_selector`

## Requirements
- R1: After reset, busy_o is 0 and the counter holds the effective interval, so the first tag falls on the effective-interval-th valid operation after reset.
- R2: With jitter off and cfg_interval = N > 0, the counter expires on every Nth cycle with op_vld = 1. Cycles with op_vld = 0 do not advance the counter.
- R3: A cfg_interval of 0 selects the parameter MIN_INTERVAL as the base interval. min_ival_o always shows MIN_INTERVAL.
- R4: The jitter source is a 16-bit Fibonacci LFSR. It shifts left with feedback bit s[15]^s[13]^s[12]^s[10] into bit 0, is seeded with SEED (default 0xACE1, never zero) and steps once per expiry. With cfg_jitter = 1, the reload value is base plus the low 8 bits of the stepped LFSR, and the reset load is base plus the low 8 bits of SEED.
- R5: cfg_interval and cfg_jitter are sampled only when the counter is loaded (at reset or at an expiry). A change between loads does not move the pending expiry.
- R6: busy_o rises in the cycle after a tag and falls in the cycle after op_done. op_done while busy_o is 0 has no effect.
- R7: An expiry while busy_o = 1 and op_done = 0 gives ev_coll_o = 1 and tag_o = 0, and leaves busy_o at 1. The counter still reloads.
- R8: An expiry in the same cycle as op_done with busy_o = 1 tags the new operation with no collision, and busy_o stays 1.
- R9: ev_pop_o equals op_vld in every cycle. ev_feed_o pulses on every expiry, so each feed pulse comes with exactly one of tag_o or ev_coll_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | An eligible operation is present this cycle |
| op_done | input | 1 | The tagged operation completes this cycle |
| cfg_interval | input | IW | Programmed sampling interval; 0 selects MIN_INTERVAL |
| cfg_jitter | input | 1 | Add pseudo-random offset to each reload |
| tag_o | output | 1 | The current operation is selected and tagged |
| busy_o | output | 1 | A tagged operation is in flight |
| ev_pop_o | output | 1 | Population event |
| ev_feed_o | output | 1 | Feed event (counter expiry) |
| ev_coll_o | output | 1 | Collision event (sample dropped) |
| min_ival_o | output | IW | Built-in minimum interval |

## Verification
The two functions that can fall in the same cycle are the completion of the in-flight operation and the expiry of the counter. The bench provokes this with an interval of 1 and op_done held high, so that every cycle both releases one sample and selects the next. Random runs also apply completion strobes at random against random intervals. The judgement is that such a cycle yields a tag and no collision, and busy_o stays high; an expiry without completion while busy must yield a collision instead.

// File: rtl/oss_pkg.sv
package oss_pkg;

    localparam int LFSR_W = 16;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef struct packed {
        logic pop;
        logic feed;
        logic tag;
        logic coll;
    } oss_ev_t;

    // Fibonacci step, taps 16,14,13,11
    function automatic lfsr_t lfsr_next(input lfsr_t s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[14:0], fb};
    endfunction

endpackage

// File: rtl/oss_lfsr.sv
module oss_lfsr
    import oss_pkg::*;
#(
    parameter lfsr_t SEED = 16'hACE1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output lfsr_t state_o,
    output lfsr_t next_o
);
    lfsr_t state_q;

    assign next_o  = lfsr_next(state_q);
    assign state_o = state_q;

    always_ff @(posedge clk) begin
        if (rst)       state_q <= SEED;
        else if (step) state_q <= next_o;
    end
endmodule

// File: rtl/oss_countdown.sv
module oss_countdown #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_vld,
    input  logic [CW-1:0] load_val,
    output logic          expire_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;

    assign expire_o = op_vld && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= load_val;
        else if (expire_o) cnt_q <= load_val;
        else if (op_vld)   cnt_q <= cnt_q - ONE;
    end
endmodule

// File: rtl/oss_flight.sv
module oss_flight (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic done,
    output logic tag_o,
    output logic coll_o,
    output logic busy_o
);
    logic busy_q;
    logic slot_free;

    // completion frees the slot in the same cycle
    assign slot_free = !busy_q || done;
    assign tag_o     = expire && slot_free;
    assign coll_o    = expire && !slot_free;
    assign busy_o    = busy_q;

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= (busy_q && !done) || tag_o;
    end
endmodule

// File: rtl/op_sample_selector.sv
module op_sample_selector
    import oss_pkg::*;
#(
    parameter int          IW           = 16,
    parameter int          JW           = 8,
    parameter logic [IW-1:0] MIN_INTERVAL = 16'd256,
    parameter lfsr_t       SEED         = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_vld,
    input  logic          op_done,
    input  logic [IW-1:0] cfg_interval,
    input  logic          cfg_jitter,
    output logic          tag_o,
    output logic          busy_o,
    output logic          ev_pop_o,
    output logic          ev_feed_o,
    output logic          ev_coll_o,
    output logic [IW-1:0] min_ival_o
);
    localparam int CW = IW + 1;

    lfsr_t         lfsr_q;
    lfsr_t         lfsr_nx;
    lfsr_t         rnd_src;
    logic          expire;
    logic [IW-1:0] base_ival;
    logic [CW-1:0] jit_add;
    logic [CW-1:0] load_val;
    oss_ev_t       ev;

    oss_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step    (expire),
        .state_o (lfsr_q),
        .next_o  (lfsr_nx)
    );

    always_comb begin
        base_ival = (cfg_interval == '0) ? MIN_INTERVAL : cfg_interval;
        rnd_src   = rst ? SEED : lfsr_nx;
        jit_add   = cfg_jitter ? CW'(rnd_src[JW-1:0]) : '0;
        load_val  = CW'(base_ival) + jit_add;
    end

    oss_countdown #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op_vld   (op_vld),
        .load_val (load_val),
        .expire_o (expire)
    );

    oss_flight u_flight (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .done   (op_done),
        .tag_o  (ev.tag),
        .coll_o (ev.coll),
        .busy_o (busy_o)
    );

    assign ev.pop  = op_vld;
    assign ev.feed = expire;

    assign tag_o      = ev.tag;
    assign ev_pop_o   = ev.pop;
    assign ev_feed_o  = ev.feed;
    assign ev_coll_o  = ev.coll;
    assign min_ival_o = MIN_INTERVAL;
endmodule

// File: rtl/oss_checker.sv
module oss_checker
    import oss_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  op_vld,
    input logic  op_done,
    input logic  tag,
    input logic  busy,
    input logic  pop,
    input logic  feed,
    input logic  coll,
    input lfsr_t lfsr
);
    a_r6_busy_sets: assert property (@(posedge clk) disable iff (rst)
        tag |=> busy);

    a_r6_busy_clears: assert property (@(posedge clk) disable iff (rst)
        (busy && op_done && !tag) |=> !busy);

    a_r6_idle_done_ignored: assert property (@(posedge clk) disable iff (rst)
        (!busy && !tag) |=> !busy);

    a_r7_coll_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        coll |-> (busy && !op_done && !tag));

    a_r7_coll_keeps_busy: assert property (@(posedge clk) disable iff (rst)
        coll |=> busy);

    a_r8_single_inflight: assert property (@(posedge clk) disable iff (rst)
        tag |-> (!busy || op_done));

    a_r9_feed_split: assert property (@(posedge clk) disable iff (rst)
        feed |-> $onehot({tag, coll}));

    a_r9_feed_needs_op: assert property (@(posedge clk) disable iff (rst)
        (tag || coll || feed) |-> (op_vld && pop));

    a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);
endmodule

bind op_sample_selector oss_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_vld  (op_vld),
    .op_done (op_done),
    .tag     (tag_o),
    .busy    (busy_o),
    .pop     (ev_pop_o),
    .feed    (ev_feed_o),
    .coll    (ev_coll_o),
    .lfsr    (lfsr_q)
);

// File: tb/op_sample_selector_tb.sv
`timescale 1ns/100ps
module op_sample_selector_tb;
    localparam int          IW   = 16;
    localparam logic [15:0] MINV = 16'd5;
    localparam logic [15:0] SEED = 16'hACE1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_vld = 1'b0;
    logic          op_done = 1'b0;
    logic [IW-1:0] cfg_interval = '0;
    logic          cfg_jitter = 1'b0;
    logic          tag_o, busy_o, ev_pop_o, ev_feed_o, ev_coll_o;
    logic [IW-1:0] min_ival_o;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    int          m_cnt;
    logic        m_busy;
    logic [15:0] m_lfsr;

    always #2.5 clk = ~clk;

    op_sample_selector #(.IW(IW), .MIN_INTERVAL(MINV), .SEED(SEED)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .op_vld       (op_vld),
        .op_done      (op_done),
        .cfg_interval (cfg_interval),
        .cfg_jitter   (cfg_jitter),
        .tag_o        (tag_o),
        .busy_o       (busy_o),
        .ev_pop_o     (ev_pop_o),
        .ev_feed_o    (ev_feed_o),
        .ev_coll_o    (ev_coll_o),
        .min_ival_o   (min_ival_o)
    );

    function automatic logic [15:0] step16(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int base_of(input logic [15:0] iv);
        return (iv == 0) ? int'(MINV) : int'(iv);
    endfunction

    function automatic int load_of(input logic [15:0] iv, input logic j, input logic [15:0] r);
        return base_of(iv) + (j ? int'(r[7:0]) : 0);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // R1: reset, model initialised from the settings present at reset
    task automatic do_reset(input logic [15:0] iv, input logic j);
        @(negedge clk);
        rst = 1'b1; op_vld = 1'b0; op_done = 1'b0;
        cfg_interval = iv; cfg_jitter = j;
        @(negedge clk);
        rst = 1'b0;
        m_lfsr = SEED;
        m_cnt  = load_of(iv, j, SEED);
        m_busy = 1'b0;
        #1;
        check("R1", "busy after reset", busy_o, 0);
    endtask

    task automatic step(input logic v, input logic d, input logic [15:0] iv,
                        input logic j, input string req);
        logic expire, e_tag, e_coll;
        @(negedge clk);
        op_vld = v; op_done = d; cfg_interval = iv; cfg_jitter = j;
        #1;
        expire = v && (m_cnt == 1);
        e_tag  = expire && (!m_busy || d);
        e_coll = expire && m_busy && !d;
        check(req, "tag_o", tag_o, e_tag);
        check("R7", "ev_coll_o", ev_coll_o, e_coll);
        check("R6", "busy_o", busy_o, m_busy);
        check("R9", "ev_pop_o", ev_pop_o, v);
        check("R9", "ev_feed_o", ev_feed_o, expire);
        m_busy = (m_busy && !d) || e_tag;
        if (expire) begin
            m_lfsr = step16(m_lfsr);
            m_cnt  = load_of(iv, j, m_lfsr);
        end else if (v) begin
            m_cnt = m_cnt - 1;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1 / R3: reset state and minimum interval report
        do_reset(16'd0, 1'b0);
        check("R3", "min_ival_o", min_ival_o, int'(MINV));
        // R3: zero interval uses MIN (5): tag on the 5th op
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 16'd0, 1'b0, "R3");

        // R2: interval 3, gaps between ops do not count
        do_reset(16'd3, 1'b0);
        for (int i = 0; i < 20; i++) step(i[0], 1'b1, 16'd3, 1'b0, "R2");

        // R7: no completions -> later expiries collide
        do_reset(16'd2, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 16'd2, 1'b0, "R7");
        // R6: completion clears busy; idle completion ignored
        step(1'b0, 1'b1, 16'd2, 1'b0, "R6");
        step(1'b0, 1'b1, 16'd2, 1'b0, "R6");
        step(1'b0, 1'b0, 16'd2, 1'b0, "R6");

        // R8: interval 1 with done every cycle: tag each cycle, never collide
        do_reset(16'd1, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 16'd1, 1'b0, "R8");

        // R5: change interval mid-count; takes effect only at next reload
        do_reset(16'd6, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 16'd2, 1'b0, "R5");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 16'd2, 1'b0, "R5");

        // R4: jitter on, reset load and reloads follow the LFSR
        do_reset(16'd4, 1'b1);
        for (int i = 0; i < 1500; i++) step(1'b1, 1'b1, 16'd4, 1'b1, "R4");

        // random mix
        do_reset(16'd7, 1'b0);
        for (int i = 0; i < 30000; i++) begin
            logic [15:0] iv;
            logic        j;
            iv = (($urandom % 10) == 0) ? 16'd0 : 16'(1 + $urandom % 12);
            j  = (($urandom % 8) == 0);
            step(($urandom % 10) < 7, ($urandom % 10) < 3, iv, j, "R2");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule